// File: doc/BRIEF.md
# Raster Test Image Generator with Timed Auto-Cycling

This block turns a raster scan into a stream of 1-bit test image pixels. For every coordinate pair presented with a valid strobe it returns one pixel of the active image, one clock later. A display engine or a frame buffer filler drives the scan and stores or shows the result.

A single 32-bit control word holds three fields: a display interval in milliseconds, an auto-cycle enable, and a fixed image select code. With auto-cycling on, a millisecond timer built from a clock-count parameter steps through the fifteen built-in images in code order and wraps at the end. With auto-cycling off, the select field picks the image. That field can also pick an externally supplied user image. A new image only takes effect at a frame-start strobe, so a frame never holds two images.

Top module: `pattern_raster_gen`

## Requirements
- R1: After reset the control word reads 0x007D0100 (interval 2000 in bits 31:12, enable 1 in bit 8, select 0x00 in bits 7:0), the image index is 0x00 and the output valid flag is low.
- R2: A write stores bits 31:12, 8 and 7:0 of the data. Bits 11:9 read back as zero. The new word is readable in the cycle after the write.
- R3: With enable 1, the cycle code starts at 0x00 and advances by one every interval x CLKS_PER_MS clocks, wrapping from 0x0E to 0x00. An interval of 0 behaves as 1. With enable 0, the timer and the cycle code are held at zero.
- R4: With enable 0, the image taken at frame start is the select field, including codes 0x0F to 0xFF.
- R5: The image index changes only in the cycle after a frame-start strobe. It then takes the cycle code (enable 1) or the select field (enable 0).
- R6: The output valid flag equals pix_valid delayed by one clock. The pixel output is 0 whenever the flag is low.
- R7: Solid and line images, with C = 2^CELL_LOG2: 0x00 all 1; 0x01 all 0; 0x06 is 1 where y mod C = 0; 0x07 is 1 where x mod C = 0; 0x0B is 1 on even y; 0x0C is 1 on even x; 0x03 is 1 where x mod C = 0, y mod C = 0, x = H_PIX-1 or y = V_PIX-1.
- R8: Diagonal images: 0x04 is 1 where x mod C = y mod C; 0x05 is 1 where (x+y) mod C = 0.
- R9: Checker images, each with 1 in the top-left cell: 0x02 uses a 4x4 grid of (H_PIX/4)x(V_PIX/4) cells; 0x08 uses four quadrants split at H_PIX/2 and V_PIX/2; 0x09 uses CxC cells; 0x0A is the inverse of 0x09; 0x0E uses cells of 2^BLOCK_LOG2.
- R10: Image 0x0D outputs bit 0 of a 16-bit LFSR. The LFSR shifts left, and its new bit 0 is bit15^bit13^bit12^bit10. It loads 0xACE1 at reset and at frame start, which takes priority. It advances once per valid pixel, and the pixel uses the value before the advance.
- R11: Image 0x0F outputs user_pix from the same cycle as pix_valid. Codes 0x10 to 0xFF output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Current control word |
| frame_start | input | 1 | Frame boundary strobe; loads the pending image |
| pix_valid | input | 1 | Coordinate valid strobe |
| pix_x | input | X_W | Column coordinate |
| pix_y | input | Y_W | Row coordinate |
| user_pix | input | 1 | External user image pixel |
| pix_out | output | 1 | Generated pixel |
| pix_out_valid | output | 1 | Pixel output valid |
| pat_idx | output | 8 | Active image code |

## Verification
A control write is due in cfg_rdata one clock after the strobe. A frame-start strobe shows in pat_idx one clock later. A pixel appears one clock after its coordinates, computed from the image index that was active in the cycle the coordinates were presented. The bench drives inputs on the falling edge. A behavioural model steps on the rising edge with the same sampled inputs and keeps these latencies. Every output is compared on the next falling edge. Directed checks read pat_idx right after each frame strobe, to confirm select-driven loading and the wrap from 0x0E to 0x00.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef struct packed {
    logic [19:0] ivl;
    logic        cen;
    logic [7:0]  sel;
  } tpg_cfg_t;

  localparam tpg_cfg_t CFG_RST = '{ivl: 20'd2000, cen: 1'b1, sel: 8'h00};

  localparam logic [7:0] P_ON      = 8'h00;
  localparam logic [7:0] P_OFF     = 8'h01;
  localparam logic [7:0] P_ANSI    = 8'h02;
  localparam logic [7:0] P_GRID    = 8'h03;
  localparam logic [7:0] P_DIAG_WE = 8'h04;
  localparam logic [7:0] P_DIAG_EW = 8'h05;
  localparam logic [7:0] P_HLINE   = 8'h06;
  localparam logic [7:0] P_VLINE   = 8'h07;
  localparam logic [7:0] P_QUAD    = 8'h08;
  localparam logic [7:0] P_CHK     = 8'h09;
  localparam logic [7:0] P_CHK_INV = 8'h0A;
  localparam logic [7:0] P_H1      = 8'h0B;
  localparam logic [7:0] P_V1      = 8'h0C;
  localparam logic [7:0] P_NOISE   = 8'h0D;
  localparam logic [7:0] P_BLOCK   = 8'h0E;
  localparam logic [7:0] P_USER    = 8'h0F;

  localparam logic [7:0]  CYC_LAST  = P_BLOCK;
  localparam logic [15:0] LFSR_SEED = 16'hACE1;

endpackage

// File: rtl/tpg_cfg_reg.sv
module tpg_cfg_reg
  import tpg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [31:0] wdata,
  output tpg_cfg_t    cfg,
  output logic [31:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_RST;
    end else if (we) begin
      cfg <= '{ivl: wdata[31:12], cen: wdata[8], sel: wdata[7:0]};
    end
  end

  assign rdata = {cfg.ivl, 3'b000, cfg.cen, cfg.sel};

  // R2
  wr_mask_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (rdata == ($past(wdata) & 32'hFFFF_F1FF)));

endmodule

// File: rtl/tpg_seq.sv
module tpg_seq
  import tpg_pkg::*;
#(
  parameter int CLKS_PER_MS = 100000
) (
  input  logic       clk,
  input  logic       rst,
  input  tpg_cfg_t   cfg,
  input  logic       frame_start,
  output logic [7:0] act
);

  localparam int PRE_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_MS - 1);

  logic [PRE_W-1:0] pre_cnt;
  logic [19:0]      ms_cnt;
  logic [19:0]      ivl_eff;
  logic [7:0]       cyc_code;
  logic [7:0]       pending;
  logic             tick, step;

  assign ivl_eff = (cfg.ivl == 20'd0) ? 20'd1 : cfg.ivl;
  assign tick    = cfg.cen && (pre_cnt == PRE_LAST);
  assign step    = tick && (ms_cnt >= (ivl_eff - 20'd1));
  assign pending = cfg.cen ? cyc_code : cfg.sel;

  always_ff @(posedge clk) begin
    if (rst || !cfg.cen) begin
      pre_cnt  <= '0;
      ms_cnt   <= '0;
      cyc_code <= P_ON;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + PRE_W'(1);
      if (step) begin
        ms_cnt   <= '0;
        cyc_code <= (cyc_code == CYC_LAST) ? P_ON : cyc_code + 8'd1;
      end else if (tick) begin
        ms_cnt <= ms_cnt + 20'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= P_ON;
    end else if (frame_start) begin
      act <= pending;
    end
  end

  // R5
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(frame_start) && !$past(rst)) |-> $stable(act));

  // R3
  cyc_off_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg.cen |=> (cyc_code == P_ON));

  // R3
  cyc_range_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_code <= CYC_LAST);

endmodule

// File: rtl/tpg_pixel.sv
module tpg_pixel
  import tpg_pkg::*;
#(
  parameter int X_W        = 11,
  parameter int Y_W        = 11,
  parameter int H_PIX      = 1280,
  parameter int V_PIX      = 800,
  parameter int CELL_LOG2  = 3,
  parameter int BLOCK_LOG2 = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           frame_start,
  input  logic           pix_valid,
  input  logic [X_W-1:0] pix_x,
  input  logic [Y_W-1:0] pix_y,
  input  logic           user_pix,
  input  logic [7:0]     act,
  output logic           pix_out,
  output logic           pix_out_valid
);

  localparam logic [X_W-1:0] X_LAST = X_W'(H_PIX - 1);
  localparam logic [Y_W-1:0] Y_LAST = Y_W'(V_PIX - 1);
  localparam logic [X_W-1:0] X_HALF = X_W'(H_PIX / 2);
  localparam logic [Y_W-1:0] Y_HALF = Y_W'(V_PIX / 2);

  logic [15:0] lfsr;
  logic        fb;
  assign fb = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];

  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      lfsr <= LFSR_SEED;
    end else if (pix_valid) begin
      lfsr <= {lfsr[14:0], fb};
    end
  end

  // column/row band thresholds for the 4x4 frame checker
  logic [2:0] col_ge, row_ge;
  for (genvar k = 1; k <= 3; k++) begin : g_band
    localparam logic [X_W-1:0] XT = X_W'((k * H_PIX) / 4);
    localparam logic [Y_W-1:0] YT = Y_W'((k * V_PIX) / 4);
    assign col_ge[k-1] = (pix_x >= XT);
    assign row_ge[k-1] = (pix_y >= YT);
  end

  logic [CELL_LOG2-1:0] xl, yl, dsum;
  logic                 on_xl, on_yl, pat_bit;

  assign xl    = pix_x[CELL_LOG2-1:0];
  assign yl    = pix_y[CELL_LOG2-1:0];
  assign dsum  = xl + yl;
  assign on_xl = (xl == '0);
  assign on_yl = (yl == '0);

  always_comb begin
    case (act)
      P_ON:      pat_bit = 1'b1;
      P_OFF:     pat_bit = 1'b0;
      P_ANSI:    pat_bit = ~((^col_ge) ^ (^row_ge));
      P_GRID:    pat_bit = on_xl | on_yl | (pix_x == X_LAST) | (pix_y == Y_LAST);
      P_DIAG_WE: pat_bit = (xl == yl);
      P_DIAG_EW: pat_bit = (dsum == '0);
      P_HLINE:   pat_bit = on_yl;
      P_VLINE:   pat_bit = on_xl;
      P_QUAD:    pat_bit = ~((pix_x >= X_HALF) ^ (pix_y >= Y_HALF));
      P_CHK:     pat_bit = ~(pix_x[CELL_LOG2] ^ pix_y[CELL_LOG2]);
      P_CHK_INV: pat_bit = pix_x[CELL_LOG2] ^ pix_y[CELL_LOG2];
      P_H1:      pat_bit = ~pix_y[0];
      P_V1:      pat_bit = ~pix_x[0];
      P_NOISE:   pat_bit = lfsr[0];
      P_BLOCK:   pat_bit = ~(pix_x[BLOCK_LOG2] ^ pix_y[BLOCK_LOG2]);
      P_USER:    pat_bit = user_pix;
      default:   pat_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_out       <= 1'b0;
      pix_out_valid <= 1'b0;
    end else begin
      pix_out_valid <= pix_valid;
      pix_out       <= pix_valid & pat_bit;
    end
  end

  // R6
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> pix_out_valid);

  // R6
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> (!pix_out_valid && !pix_out));

  // R10
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    lfsr != 16'h0000);

  // R10
  lfsr_reseed_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (lfsr == LFSR_SEED));

endmodule

// File: rtl/pattern_raster_gen.sv
module pattern_raster_gen
  import tpg_pkg::*;
#(
  parameter int CLKS_PER_MS = 100000,
  parameter int X_W         = 11,
  parameter int Y_W         = 11,
  parameter int H_PIX       = 1280,
  parameter int V_PIX       = 800,
  parameter int CELL_LOG2   = 3,
  parameter int BLOCK_LOG2  = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [31:0]    cfg_wdata,
  output logic [31:0]    cfg_rdata,
  input  logic           frame_start,
  input  logic           pix_valid,
  input  logic [X_W-1:0] pix_x,
  input  logic [Y_W-1:0] pix_y,
  input  logic           user_pix,
  output logic           pix_out,
  output logic           pix_out_valid,
  output logic [7:0]     pat_idx
);

  tpg_cfg_t cfg;

  tpg_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  tpg_seq #(.CLKS_PER_MS(CLKS_PER_MS)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .cfg         (cfg),
    .frame_start (frame_start),
    .act         (pat_idx)
  );

  tpg_pixel #(
    .X_W        (X_W),
    .Y_W        (Y_W),
    .H_PIX      (H_PIX),
    .V_PIX      (V_PIX),
    .CELL_LOG2  (CELL_LOG2),
    .BLOCK_LOG2 (BLOCK_LOG2)
  ) u_pix (
    .clk           (clk),
    .rst           (rst),
    .frame_start   (frame_start),
    .pix_valid     (pix_valid),
    .pix_x         (pix_x),
    .pix_y         (pix_y),
    .user_pix      (user_pix),
    .act           (pat_idx),
    .pix_out       (pix_out),
    .pix_out_valid (pix_out_valid)
  );

endmodule

// File: tb/pattern_raster_gen_test.sv
`timescale 1ns/1ps
module pattern_raster_gen_test;

  localparam int CPM = 3;
  localparam int XW  = 6;
  localparam int YW  = 5;
  localparam int H   = 32;
  localparam int V   = 16;
  localparam int CL  = 2;
  localparam int BL  = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic          frame_start = 1'b0;
  logic          pix_valid = 1'b0;
  logic [XW-1:0] pix_x = '0;
  logic [YW-1:0] pix_y = '0;
  logic          user_pix = 1'b0;
  logic          pix_out, pix_out_valid;
  logic [7:0]    pat_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit started = 1'b0;

  always #2 clk = ~clk;

  pattern_raster_gen #(
    .CLKS_PER_MS(CPM), .X_W(XW), .Y_W(YW), .H_PIX(H), .V_PIX(V),
    .CELL_LOG2(CL), .BLOCK_LOG2(BL)
  ) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .frame_start(frame_start), .pix_valid(pix_valid),
    .pix_x(pix_x), .pix_y(pix_y), .user_pix(user_pix), .pix_out(pix_out),
    .pix_out_valid(pix_out_valid), .pat_idx(pat_idx)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act_v,
                       input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [19:0] m_ivl;
  logic        m_cen;
  logic [7:0]  m_sel;
  int          m_pre;
  int          m_ms;
  int          m_cyc;
  logic [7:0]  m_act;
  logic [15:0] m_lfsr;
  logic        m_vld, m_pix;
  logic [7:0]  m_pcode;

  function automatic bit ref_pix(input int code, input int x, input int y,
                                 input logic [15:0] l, input bit u);
    int c = 1 << CL;
    int b = 1 << BL;
    case (code)
      0:  return 1'b1;
      1:  return 1'b0;
      2:  return (((x / (H/4)) + (y / (V/4))) % 2) == 0;
      3:  return (x % c == 0) || (y % c == 0) || (x == H-1) || (y == V-1);
      4:  return (x % c) == (y % c);
      5:  return ((x + y) % c) == 0;
      6:  return (y % c) == 0;
      7:  return (x % c) == 0;
      8:  return (x >= H/2) == (y >= V/2);
      9:  return (((x / c) + (y / c)) % 2) == 0;
      10: return (((x / c) + (y / c)) % 2) == 1;
      11: return (y % 2) == 0;
      12: return (x % 2) == 0;
      13: return l[0];
      14: return (((x / b) + (y / b)) % 2) == 0;
      15: return u;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string code_tag(input logic [7:0] code);
    case (code)
      8'h00, 8'h01, 8'h03, 8'h06, 8'h07, 8'h0B, 8'h0C: return "R7";
      8'h04, 8'h05:                                    return "R8";
      8'h02, 8'h08, 8'h09, 8'h0A, 8'h0E:               return "R9";
      8'h0D:                                           return "R10";
      default:                                         return "R11";
    endcase
  endfunction

  always @(posedge clk) begin : model
    int ie;
    bit tk, st;
    if (rst) begin
      m_ivl = 20'd2000; m_cen = 1'b1; m_sel = 8'h00;
      m_pre = 0; m_ms = 0; m_cyc = 0; m_act = 8'h00;
      m_lfsr = 16'hACE1; m_vld = 1'b0; m_pix = 1'b0; m_pcode = 8'h00;
    end else begin
      // pixel stage uses current active code and LFSR value
      m_vld   = pix_valid;
      m_pcode = m_act;
      m_pix   = pix_valid ? ref_pix(int'(m_act), int'(pix_x), int'(pix_y), m_lfsr, user_pix) : 1'b0;
      if (frame_start) m_lfsr = 16'hACE1;
      else if (pix_valid)
        m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
      if (frame_start) m_act = m_cen ? 8'(m_cyc) : m_sel;
      if (!m_cen) begin
        m_pre = 0; m_ms = 0; m_cyc = 0;
      end else begin
        ie = (m_ivl == 0) ? 1 : int'(m_ivl);
        tk = (m_pre == CPM - 1);
        st = tk && (m_ms >= ie - 1);
        m_pre = tk ? 0 : m_pre + 1;
        if (st) begin
          m_ms = 0;
          m_cyc = (m_cyc == 14) ? 0 : m_cyc + 1;
        end else if (tk) m_ms = m_ms + 1;
      end
      if (cfg_we) begin
        m_ivl = cfg_wdata[31:12]; m_cen = cfg_wdata[8]; m_sel = cfg_wdata[7:0];
      end
    end
    started <= 1'b1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      check(cfg_rdata === {m_ivl, 3'b000, m_cen, m_sel}, "R2 cfg_rdata",
            cfg_rdata, {m_ivl, 3'b000, m_cen, m_sel});
      check(pat_idx === m_act, "R3/R5 pat_idx", 32'(pat_idx), 32'(m_act));
      check(pix_out_valid === m_vld, "R6 pix_out_valid", 32'(pix_out_valid), 32'(m_vld));
      check(pix_out === m_pix, m_vld ? code_tag(m_pcode) : "R6",
            32'(pix_out), 32'(m_pix));
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic fs();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic px(input int x, input int y);
    @(negedge clk);
    pix_valid = 1'b1; pix_x = XW'(x); pix_y = YW'(y);
    user_pix = 1'(x) ^ 1'(y >> 1);
  endtask

  task automatic scan(input bit gaps);
    for (int y = 0; y < V; y++) begin
      for (int x = 0; x < H; x++) begin
        px(x, y);
        if (gaps && ((x % 3) == 1)) begin
          @(negedge clk); pix_valid = 1'b0;
        end
      end
    end
    @(negedge clk); pix_valid = 1'b0;
  endtask

  initial begin
    logic [7:0] code;
    logic [7:0] prev;
    bit wrap_seen;
    int maxc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(cfg_rdata === 32'h007D_0100, "R1 reset word", cfg_rdata, 32'h007D_0100);
    check(pat_idx === 8'h00, "R1 reset index", 32'(pat_idx), 32'h0);
    check(pix_out_valid === 1'b0, "R1 reset valid", 32'(pix_out_valid), 32'h0);

    // every code with cycling disabled (R4 and pixel requirements)
    for (int c = 0; c < 18; c++) begin
      code = (c < 16) ? 8'(c) : ((c == 16) ? 8'h10 : 8'hFF);
      wr({20'd5, 3'b000, 1'b0, code});
      fs();
      check(pat_idx === code, "R4 select taken at frame start", 32'(pat_idx), 32'(code));
      scan(c[0]);
    end

    // R2 unused bits read as zero
    wr(32'h0000_0E05);
    check(cfg_rdata === 32'h0000_0005, "R2 bits 11:9 zero", cfg_rdata, 32'h5);

    // R5 select change without frame start keeps the old image
    wr({20'd5, 3'b000, 1'b0, 8'h01});
    scan(1'b0);
    check(pat_idx === 8'hFF, "R5 no frame start", 32'(pat_idx), 32'hFF);

    // R3 cycling with interval 2
    wr({20'd2, 3'b000, 1'b1, 8'h07});
    wrap_seen = 1'b0; maxc = 0; prev = pat_idx;
    for (int i = 0; i < 150; i++) begin
      fs();
      if (prev == 8'h0E && pat_idx == 8'h00) wrap_seen = 1'b1;
      if (int'(pat_idx) > maxc) maxc = int'(pat_idx);
      prev = pat_idx;
      px(i % H, (i * 3) % V);
      px((i * 5) % H, i % V);
      @(negedge clk); pix_valid = 1'b0;
    end
    check(wrap_seen, "R3 wrap 0x0E to 0x00", 32'(wrap_seen), 32'h1);
    check(maxc == 14, "R3 highest cycled code", 32'(maxc), 32'd14);

    // R3 zero interval behaves as one millisecond
    wr({20'd0, 3'b000, 1'b1, 8'h00});
    for (int i = 0; i < 60; i++) begin
      fs();
      px((i * 7) % H, (i * 2) % V);
      @(negedge clk); pix_valid = 1'b0;
    end

    // R3 disabling returns the sequence to code 0
    wr({20'd1, 3'b000, 1'b0, 8'h03});
    wr({20'd1, 3'b000, 1'b1, 8'h03});
    fs();
    check(pat_idx === 8'h00, "R3 restart at code 0", 32'(pat_idx), 32'h0);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule